// File: doc/BRIEF.md
# Serial Control Port with Status Flags and Interrupt Lines

This block is the host-facing control port of a receiver chip. An external controller reaches a small bank of 8-bit registers over a four-wire serial link: an active-low select, a serial clock, a data input, and a data output with a separate output-enable for the pad. Every frame is sixteen bits long. It carries a chip address, a direction bit, a register address and one data byte. Control registers can be written and read back. A status register collects flags from the receiver's internal event lines.

Half of the status flags are sticky. They latch a one-cycle event pulse and hold it until the host reads the status register. The other half follow level inputs directly. Two interrupt lines each OR together the status flags that their own mask register leaves enabled. The host can therefore route any mix of conditions to either line.

The serial lines are asynchronous to the system clock. They are brought into the clock domain through synchronizers and oversampled, so the serial clock must run well below the system clock (six or more system cycles per half period).

Top module: `ctl_serial_port`

## Requirements
- R1: A frame is 16 bits sampled on rising serial-clock edges while `csel_n` is low, most significant bit first. Bits 15:14 are the chip address, bit 13 is the direction, bits 12:8 are the register address and bits 7:0 are the data byte.
- R2: Only chip address 2'b00 is accepted. A frame with any other chip address writes nothing, clears nothing, and never enables `sdout_oe`.
- R3: The direction bit set to 1 means write and 0 means read. A write takes effect on the 16th rising edge. Addresses 0x00–0x02 are control registers that reset to 0x00. Address 0x03 is the mask for `irq0` and 0x04 is the mask for `irq1`; both masks reset to 0xFF.
- R4: `sdout_oe` is low except in the data phase of an accepted read. It rises on the falling edge after the 8th rising edge. It falls on the falling edge after the 16th rising edge, or when `csel_n` goes high.
- R5: Read data leaves on `sdout` most significant bit first. Each bit changes only on a falling serial-clock edge. Address 0x05 returns the status byte and addresses 0x06–0x1F read 0x00. Writes to 0x05–0x1F change nothing.
- R6: The status byte is laid out as follows. Bit 0 is `ev_qbuf`, bit 1 is `ev_cbuf`, bit 2 is `ev_fschg` and bit 3 is `ev_perr`; these four are sticky. Bit 4 is `lv_nonpcm`, bit 5 is `lv_invalid`, bit 6 is `lv_auto` and bit 7 is `lv_unlock`; these four follow their inputs.
- R7: A one-cycle pulse sets its sticky flag, and the flag stays set until an accepted read of 0x05. That read clears all four sticky flags on the 8th rising edge, after it has captured their old values for shifting out. A pulse in the same cycle as the clear survives the clear and does not appear in that read's data.
- R8: `irqN` is the OR of the status bits whose bit in mask N is 0; a mask bit of 1 blocks that bit. It is registered and follows the status with one clock of delay.
- R9: If `csel_n` goes high before the 16th rising edge, the frame is abandoned with no write. The next frame starts again at bit 15.
- R10: After reset, `sdout_oe`, `irq0` and `irq1` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csel_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host, idle low |
| sdin | input | 1 | Serial data from the host |
| sdout | output | 1 | Serial read data |
| sdout_oe | output | 1 | Output enable for the `sdout` pad driver |
| ev_qbuf | input | 1 | Event pulse: subcode buffer updated |
| ev_cbuf | input | 1 | Event pulse: channel-status buffer changed |
| ev_fschg | input | 1 | Event pulse: sample-rate or format change |
| ev_perr | input | 1 | Event pulse: parity error |
| lv_nonpcm | input | 1 | Level: non-PCM stream present |
| lv_invalid | input | 1 | Level: validity flag set |
| lv_auto | input | 1 | Level: compressed stream auto-detected |
| lv_unlock | input | 1 | Level: clock recovery unlocked |
| irq0 | output | 1 | Interrupt line 0 |
| irq1 | output | 1 | Interrupt line 1 |

## Verification
An event pulse can land on a sticky flag in the same system cycle in which a status read clears it. The bench provokes this by sweeping the position of a single `ev_cbuf` pulse, one system cycle at a time, across the window around the 8th rising edge of a read of 0x05. After each sweep step a second status read is made. The step is judged correct when exactly one of the two reads reports the flag, so the event is neither lost nor reported twice. A further check confirms that the sweep produced both outcomes.

// File: rtl/ctl_sp_pkg.sv
package ctl_sp_pkg;
  localparam int CHIP_W     = 2;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 8;
  localparam int HDR_W      = CHIP_W + 1 + ADDR_W;
  localparam int FRAME_W    = HDR_W + DATA_W;
  localparam int NUM_STICKY = 4;
  localparam int NUM_LEVEL  = DATA_W - NUM_STICKY;
  localparam int NUM_IRQ    = 2;

  localparam logic [CHIP_W-1:0] CHIP_ID    = '0;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 5'h05;

  typedef struct packed {
    logic [CHIP_W-1:0] chip;
    logic              wr;
    logic [ADDR_W-1:0] addr;
  } hdr_t;
endpackage

// File: rtl/ctl_sp_sync.sv
module ctl_sp_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stg_d = d;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ctl_sp_frame.sv
module ctl_sp_frame
  import ctl_sp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_req,
  output logic              wr_req,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              dout,
  output logic              dout_oe
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_HDR_LAST = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] CNT_HDR      = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_LAST     = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL     = CNT_W'(FRAME_W);

  logic                 sclk_q, sclk_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [FRAME_W-2:0]   rx_q, rx_d;
  logic [DATA_W-1:0]    tx_q, tx_d;
  logic                 oe_q, oe_d;
  logic                 rd_act_q, rd_act_d;

  logic                 rise, fall, hdr_done, frame_done;
  logic [FRAME_W-1:0]   rx_next;
  hdr_t                 hdr_now, hdr_full;

  assign rx_next    = {rx_q, din};
  assign hdr_now    = hdr_t'(rx_next[HDR_W-1:0]);
  assign hdr_full   = hdr_t'(rx_next[FRAME_W-1:DATA_W]);
  assign rise       = ~cs_n & sclk & ~sclk_q;
  assign fall       = ~cs_n & ~sclk & sclk_q;
  assign hdr_done   = rise && (cnt_q == CNT_HDR_LAST);
  assign frame_done = rise && (cnt_q == CNT_LAST);

  assign rd_req   = hdr_done && (hdr_now.chip == CHIP_ID) && !hdr_now.wr;
  assign wr_req   = frame_done && (hdr_full.chip == CHIP_ID) && hdr_full.wr;
  assign reg_addr = hdr_done ? hdr_now.addr : hdr_full.addr;
  assign wr_data  = rx_next[DATA_W-1:0];

  always_comb begin
    sclk_d   = sclk;
    cnt_d    = cnt_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    oe_d     = oe_q;
    rd_act_d = rd_act_q;
    if (cs_n) begin
      cnt_d    = '0;
      oe_d     = 1'b0;
      rd_act_d = 1'b0;
    end else begin
      if (rise && (cnt_q != CNT_FULL)) begin
        cnt_d = cnt_q + 1'b1;
        rx_d  = rx_next[FRAME_W-2:0];
      end
      if (hdr_done) rd_act_d = rd_req;
      if (rd_req)   tx_d     = rd_data;
      if (fall && rd_act_q) begin
        if (cnt_q == CNT_HDR)       oe_d = 1'b1;
        else if (cnt_q == CNT_FULL) oe_d = 1'b0;
        else if (oe_q)              tx_d = {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      oe_q     <= 1'b0;
      rd_act_q <= 1'b0;
    end else begin
      sclk_q   <= sclk_d;
      cnt_q    <= cnt_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      oe_q     <= oe_d;
      rd_act_q <= rd_act_d;
    end
  end

  assign dout    = oe_q & tx_q[DATA_W-1];
  assign dout_oe = oe_q;

  AST_OE_OFF_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !dout_oe); // R4
  AST_DOUT_STABLE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && rise) |=> $stable(dout)); // R5
  AST_NO_WRITE_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !wr_req && !rd_req); // R9
endmodule

// File: rtl/ctl_sp_regs.sv
module ctl_sp_regs
  import ctl_sp_pkg::*;
#(
  parameter logic [DATA_W-1:0] MASK_RST = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_req,
  input  logic                  wr_req,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [NUM_STICKY-1:0] ev_set,
  input  logic [NUM_LEVEL-1:0]  lv_in,
  output logic [DATA_W-1:0]     rd_data,
  output logic [NUM_IRQ-1:0]    irq
);
  localparam int NUM_CTRL = int'(ADR_STATUS) - NUM_IRQ;

  logic [NUM_CTRL-1:0][DATA_W-1:0]   ctrl_q, ctrl_d;
  logic [NUM_IRQ-1:0][DATA_W-1:0]    mask_q, mask_d;
  logic [NUM_STICKY-1:0]             sticky_q, sticky_d;
  logic [NUM_IRQ-1:0]                irq_q, irq_d;
  logic [DATA_W-1:0]                 status;
  logic                              clr;

  assign status = {lv_in, sticky_q};
  assign clr    = rd_req && (reg_addr == ADR_STATUS);

  always_comb begin
    ctrl_d = ctrl_q;
    for (int k = 0; k < NUM_CTRL; k++) begin
      if (wr_req && (reg_addr == ADDR_W'(k))) ctrl_d[k] = wr_data;
    end
  end

  generate
    for (genvar ch = 0; ch < NUM_IRQ; ch++) begin : g_irq
      localparam logic [ADDR_W-1:0] MADR = ADDR_W'(NUM_CTRL + ch);
      assign mask_d[ch] = (wr_req && (reg_addr == MADR)) ? wr_data : mask_q[ch];
      assign irq_d[ch]  = |(status & ~mask_q[ch]);
    end
  endgenerate

  always_comb begin
    sticky_d = (clr ? '0 : sticky_q) | ev_set;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_CTRL; k++) begin
      if (reg_addr == ADDR_W'(k)) rd_data = ctrl_q[k];
    end
    for (int ch = 0; ch < NUM_IRQ; ch++) begin
      if (reg_addr == ADDR_W'(NUM_CTRL + ch)) rd_data = mask_q[ch];
    end
    if (reg_addr == ADR_STATUS) rd_data = status;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      mask_q   <= {NUM_IRQ{MASK_RST}};
      sticky_q <= '0;
      irq_q    <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      mask_q   <= mask_d;
      sticky_q <= sticky_d;
      irq_q    <= irq_d;
    end
  end

  assign irq = irq_q;

  AST_EVENT_NEVER_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set != '0) |=> ((sticky_q & $past(ev_set)) == $past(ev_set))); // R7
  AST_READ_CLEARS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (ev_set == '0)) |=> (sticky_q == '0)); // R7
  AST_IRQ0_FULLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q[0]) |=> !irq[0]); // R8
  AST_IRQ1_FULLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q[1]) |=> !irq[1]); // R8
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
  import ctl_sp_pkg::*;
#(
  parameter logic [DATA_W-1:0] MASK_RST    = '1,
  parameter int                SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csel_n,
  input  logic sclk,
  input  logic sdin,
  output logic sdout,
  output logic sdout_oe,
  input  logic ev_qbuf,
  input  logic ev_cbuf,
  input  logic ev_fschg,
  input  logic ev_perr,
  input  logic lv_nonpcm,
  input  logic lv_invalid,
  input  logic lv_auto,
  input  logic lv_unlock,
  output logic irq0,
  output logic irq1
);
  logic              rst_sn;
  logic [2:0]        pins_s;
  logic              rd_req, wr_req;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [NUM_IRQ-1:0] irq;

  ctl_sp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sn)
  );

  ctl_sp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_pin_sync (
    .clk(clk), .rst_n(rst_sn), .d({csel_n, sclk, sdin}), .q(pins_s)
  );

  ctl_sp_frame u_frame (
    .clk(clk), .rst_n(rst_sn),
    .cs_n(pins_s[2]), .sclk(pins_s[1]), .din(pins_s[0]),
    .rd_data(rd_data), .rd_req(rd_req), .wr_req(wr_req),
    .reg_addr(reg_addr), .wr_data(wr_data),
    .dout(sdout), .dout_oe(sdout_oe)
  );

  ctl_sp_regs #(.MASK_RST(MASK_RST)) u_regs (
    .clk(clk), .rst_n(rst_sn),
    .rd_req(rd_req), .wr_req(wr_req), .reg_addr(reg_addr), .wr_data(wr_data),
    .ev_set({ev_perr, ev_fschg, ev_cbuf, ev_qbuf}),
    .lv_in({lv_unlock, lv_auto, lv_invalid, lv_nonpcm}),
    .rd_data(rd_data), .irq(irq)
  );

  assign irq0 = irq[0];
  assign irq1 = irq[1];
endmodule

// File: tb/ctl_serial_port_test.sv
module ctl_serial_port_test;
  localparam int HALF = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, csel_n, sclk, sdin;
  logic [3:0] evp, lvl;
  logic sdout, sdout_oe, irq0, irq1;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  logic [7:0] m_reg [0:4];
  logic [3:0] m_stk;

  ctl_serial_port uut (
    .clk(clk), .rst_n(rst_n), .csel_n(csel_n), .sclk(sclk), .sdin(sdin),
    .sdout(sdout), .sdout_oe(sdout_oe),
    .ev_qbuf(evp[0]), .ev_cbuf(evp[1]), .ev_fschg(evp[2]), .ev_perr(evp[3]),
    .lv_nonpcm(lvl[0]), .lv_invalid(lvl[1]), .lv_auto(lvl[2]), .lv_unlock(lvl[3]),
    .irq0(irq0), .irq1(irq1)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: run did not finish act=%0d exp=<190000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [4:0] a);
    if (a < 5)       return m_reg[a];
    else if (a == 5) return {lvl, m_stk};
    else             return 8'h00;
  endfunction

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nbits < 16 abandons the frame early.
  task automatic xfer(input logic [1:0] chip, input logic wr, input logic [4:0] a,
                      input logic [7:0] wd, input int nbits,
                      output logic [7:0] rd, output logic oe_ok);
    logic [15:0] f;
    logic oe_exp;
    f = {chip, wr, a, wd};
    oe_exp = (chip == 2'b00) && !wr;
    rd = 8'h00;
    oe_ok = 1'b1;
    csel_n = 1'b0;
    waitn(HALF);
    for (int k = 0; k < nbits; k++) begin
      sdin = f[15-k];
      waitn(HALF);
      if (k >= 8) rd = {rd[6:0], sdout};
      if (sdout_oe !== (oe_exp && (k >= 8))) oe_ok = 1'b0;
      sclk = 1'b1;
      waitn(HALF);
      sclk = 1'b0;
    end
    waitn(HALF);
    if (sdout_oe !== 1'b0 && nbits == 16) oe_ok = 1'b0;
    csel_n = 1'b1;
    waitn(2 * HALF);
    if (sdout_oe !== 1'b0) oe_ok = 1'b0;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] r;
    logic ok;
    xfer(2'b00, 1'b1, a, d, 16, r, ok);
    chk("R4 write frame keeps sdout_oe low", {31'd0, ok}, 32'd1);
    if (a < 5) m_reg[a] = d;
  endtask

  task automatic rd_reg(input logic [4:0] a, input string req);
    logic [7:0] r;
    logic ok;
    xfer(2'b00, 1'b0, a, 8'h00, 16, r, ok);
    chk(req, {24'd0, r}, {24'd0, exp_read(a)});
    chk("R4 read frame sdout_oe window", {31'd0, ok}, 32'd1);
    if (a == 5) m_stk = 4'h0;
  endtask

  initial begin
    logic [7:0] r1, r2, m, bitv;
    logic ok;
    int hits, misses;

    rst_n = 1'b0; csel_n = 1'b1; sclk = 1'b0; sdin = 1'b0;
    evp = 4'h0; lvl = 4'h0;
    for (int i = 0; i < 3; i++) m_reg[i] = 8'h00;
    m_reg[3] = 8'hFF; m_reg[4] = 8'hFF;
    m_stk = 4'h0;
    waitn(5);
    rst_n = 1'b1;
    waitn(5);

    // R10: reset state
    chk("R10 sdout_oe after reset", {31'd0, sdout_oe}, 32'd0);
    chk("R10 irq0 after reset", {31'd0, irq0}, 32'd0);
    chk("R10 irq1 after reset", {31'd0, irq1}, 32'd0);
    for (int a = 0; a < 32; a++) rd_reg(5'(a), "R10 R5 reset read map");

    // R1 R3 R5: write every address with an asymmetric pattern, read all back
    for (int a = 0; a < 32; a++) wr_reg(5'(a), 8'((a * 37 + 5) ^ 8'hA6));
    for (int a = 0; a < 32; a++) rd_reg(5'(a), "R1 R3 R5 write then read map");

    // R2: foreign chip addresses change nothing and never drive sdout
    for (int c = 1; c < 4; c++) begin
      for (int a = 0; a < 6; a++) begin
        xfer(2'(c), 1'b1, 5'(a), 8'(~(a * 19)), 16, r1, ok);
        chk("R2 foreign write keeps sdout_oe low", {31'd0, ok}, 32'd1);
      end
      xfer(2'(c), 1'b0, 5'd1, 8'h00, 16, r1, ok);
      chk("R2 foreign read keeps sdout_oe low", {31'd0, ok}, 32'd1);
    end
    for (int a = 0; a < 5; a++) rd_reg(5'(a), "R2 registers unchanged by foreign frames");

    // R9: frames abandoned after 1..15 bits write nothing
    for (int n = 1; n < 16; n++) begin
      xfer(2'b00, 1'b1, 5'd0, 8'(n * 11 + 1), n, r1, ok);
      chk("R9 abort keeps sdout_oe low", {31'd0, ok}, 32'd1);
      rd_reg(5'd0, "R9 abandoned write has no effect");
    end
    xfer(2'b00, 1'b0, 5'd3, 8'h00, 11, r1, ok);
    chk("R9 R4 aborted read releases sdout_oe", {31'd0, ok}, 32'd1);
    wr_reg(5'd2, 8'h3C);
    rd_reg(5'd2, "R9 full frame after aborts lands");

    // R6 R7 R8: each status bit against a set of mask patterns
    for (int i = 0; i < 8; i++) begin
      bitv = 8'(1 << i);
      for (int p = 0; p < 5; p++) begin
        case (p)
          0: m = 8'h00;
          1: m = 8'hFF;
          2: m = ~bitv;
          3: m = bitv;
          default: m = 8'h55;
        endcase
        wr_reg(5'd3, m);
        wr_reg(5'd4, ~m);
        if (i < 4) begin
          evp[i] = 1'b1; waitn(1); evp[i] = 1'b0;
          m_stk[i] = 1'b1;
        end else begin
          lvl[i-4] = 1'b1;
        end
        waitn(4);
        chk("R8 irq0 follows unmasked status", {31'd0, irq0}, {31'd0, |(bitv & ~m)});
        chk("R8 irq1 follows unmasked status", {31'd0, irq1}, {31'd0, |(bitv & m)});
        if (i < 4) begin
          waitn(40);
          chk("R7 sticky flag held before read", {31'd0, irq0 | irq1}, 32'd1);
          rd_reg(5'd5, "R6 R7 sticky flag position in status");
          waitn(4);
          chk("R7 status read clears sticky irq0", {31'd0, irq0}, 32'd0);
          chk("R7 status read clears sticky irq1", {31'd0, irq1}, 32'd0);
        end else begin
          rd_reg(5'd5, "R6 level flag position in status");
          chk("R6 level flag not cleared by read", {31'd0, irq0 | irq1}, 32'd1);
          lvl[i-4] = 1'b0;
          waitn(4);
          chk("R8 irq drops with level input", {31'd0, irq0 | irq1}, 32'd0);
        end
      end
    end

    // R7: event pulse swept across the read-clear cycle
    wr_reg(5'd3, 8'hFF);
    wr_reg(5'd4, 8'hFF);
    hits = 0; misses = 0;
    for (int off = 88; off < 108; off++) begin
      fork
        xfer(2'b00, 1'b0, 5'd5, 8'h00, 16, r1, ok);
        begin
          waitn(off);
          evp[1] = 1'b1;
          waitn(1);
          evp[1] = 1'b0;
        end
      join
      xfer(2'b00, 1'b0, 5'd5, 8'h00, 16, r2, ok);
      chk("R7 coincident event reported exactly once", {31'd0, r1[1] ^ r2[1]}, 32'd1);
      if (r1[1]) hits++; else misses++;
    end
    chk("R7 sweep reached both sides of the clear", {31'd0, (hits > 0) && (misses > 0)}, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule